// File: doc/BRIEF.md
# Multi-Palette Colour Register Unit

This block is the register front end for six 9-bit colour palettes: a primary and a secondary palette for each of three display layers (character cells, the bitmap layer and sprites). Software reaches every entry through a small window of byte-wide registers. An index register picks an entry and a control register picks the palette. Two colour registers move data. One takes a single byte and widens it to nine bits. The other takes two bytes and carries all nine bits exactly. The palettes are held in internal storage. A separate debug port reads any entry of any palette without disturbing the register state. A plain ink-mask byte is also kept here for the display logic.

The rules for moving the index are the part that matters. Reads never move it. A one-byte colour write always advances it by one. A two-byte colour write advances it only after its second byte has been stored. Writing the index, the control register or the one-byte colour register returns the two-byte sequence to its first byte.

Top module: `palreg_unit`

## Requirements
- R1: A write to register 0x40 loads the entry index from the data byte. A read of 0x40 returns the current index.
- R2: A read of register 0x41 returns bits [8:1] of the selected entry. No read of any register changes the index, an entry or the two-byte sequence.
- R3: A write to register 0x41 stores {data, data[1] | data[0]} into the selected entry and advances the index by one.
- R4: Register 0x43 bits [6:4] select the palette that reads and writes use. Bit 6 picks the secondary palette. Bits [5:4] pick the layer: 00 character cells, 01 bitmap, 10 sprites, and 11 is treated as character cells. Bit 0 drives the ext_mode output. All eight bits read back, so writing 0x68 selects the secondary sprite palette and clears ext_mode.
- R5: A read of register 0x44 returns 0x00 or 0x01, equal to bit 0 of the selected entry.
- R6: A write to register 0x44 alternates between two steps. The first write only holds the byte, leaving the index and all entries unchanged. The second write stores {held byte, data[0]} into the selected entry and advances the index by one.
- R7: Register 0x42 is an ink-mask byte that reads back whatever was last written to it.
- R8: A write to register 0x40, 0x41 or 0x43 returns the register 0x44 sequence to its first step.
- R9: Whenever the index is advanced from 255, it wraps to 0.
- R10: After reset the index is 0, register 0x43 is 0x00 (character-cell primary palette, ext_mode low), the ink mask is 0x07 and register 0x44 is at its first step.
- R11: A write to any register number outside 0x40 to 0x44 changes no state, and a read of such a number returns 0x00.
- R12: The debug port returns the 9-bit entry at dbg_idx of the palette named by dbg_pal, which uses the same encoding as register 0x43 bits [6:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 8 | Register number for the current access |
| wr_en | input | 1 | Write strobe for reg_sel/wr_data |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read value of register reg_sel (combinational) |
| ext_mode | output | 1 | Extended character-colour mode enable (register 0x43 bit 0) |
| dbg_pal | input | 3 | Palette selector for the debug port |
| dbg_idx | input | IDX_W | Entry index for the debug port |
| dbg_color | output | 9 | 9-bit entry at the debug address |

## Verification
The bench builds the block with its default IDX_W of 8. With that width each palette has 256 entries and the index register spans its full byte, so a single write can place the index at 255. The wrap to 0 is then checked on both the one-byte path and the two-byte path. Separate palettes are told apart on the debug port by writing the same index in two palettes and checking that neither write disturbs the other.

// File: rtl/palreg_unit.sv
module palreg_unit #(
  parameter int IDX_W = 8,
  parameter logic [7:0] A_INDEX  = 8'h40,
  parameter logic [7:0] A_COLOR8 = 8'h41,
  parameter logic [7:0] A_INK    = 8'h42,
  parameter logic [7:0] A_CTRL   = 8'h43,
  parameter logic [7:0] A_COLOR9 = 8'h44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             ext_mode,
  input  logic [2:0]       dbg_pal,
  input  logic [IDX_W-1:0] dbg_idx,
  output logic [8:0]       dbg_color
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NPAL  = 6;
  localparam int AW    = IDX_W + 3;

  function automatic logic [2:0] slot_of(input logic [2:0] code);
    logic [1:0] layer;
    layer = (code[1:0] == 2'd3) ? 2'd0 : code[1:0];
    return {layer, code[2]};
  endfunction

  logic [8:0]       mem [0:NPAL*DEPTH-1];
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       ctrl_q, ink_q, hold_q;
  logic             phase_q;

  wire we_idx  = wr_en && reg_sel == A_INDEX;
  wire we_c8   = wr_en && reg_sel == A_COLOR8;
  wire we_ink  = wr_en && reg_sel == A_INK;
  wire we_ctrl = wr_en && reg_sel == A_CTRL;
  wire we_c9   = wr_en && reg_sel == A_COLOR9;

  wire [AW-1:0] cur_a = {slot_of(ctrl_q[6:4]), idx_q};
  wire [AW-1:0] dbg_a = {slot_of(dbg_pal), dbg_idx};
  wire [8:0]    cur   = mem[cur_a];

  assign dbg_color = mem[dbg_a];
  assign ext_mode  = ctrl_q[0];

  always_comb begin
    case (reg_sel)
      A_INDEX:  rd_data = 8'(idx_q);
      A_COLOR8: rd_data = cur[8:1];
      A_INK:    rd_data = ink_q;
      A_CTRL:   rd_data = ctrl_q;
      A_COLOR9: rd_data = {7'd0, cur[0]};
      default:  rd_data = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (we_c8)
      mem[cur_a] <= {wr_data, wr_data[1] | wr_data[0]};
    else if (we_c9 && phase_q)
      mem[cur_a] <= {hold_q, wr_data[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ctrl_q  <= 8'h00;
      ink_q   <= 8'h07;
      hold_q  <= 8'h00;
      phase_q <= 1'b0;
    end else begin
      if (we_idx) begin
        idx_q   <= wr_data[IDX_W-1:0];
        phase_q <= 1'b0;
      end
      if (we_ctrl) begin
        ctrl_q  <= wr_data;
        phase_q <= 1'b0;
      end
      if (we_ink)
        ink_q <= wr_data;
      if (we_c8) begin
        idx_q   <= idx_q + 1'b1;
        phase_q <= 1'b0;
      end
      if (we_c9) begin
        if (!phase_q) begin
          hold_q  <= wr_data;
          phase_q <= 1'b1;
        end else begin
          idx_q   <= idx_q + 1'b1;
          phase_q <= 1'b0;
        end
      end
    end
  end
endmodule

module palreg_unit_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       reg_sel,
  input logic [7:0]       wr_data,
  input logic [IDX_W-1:0] idx,
  input logic             phase,
  input logic [7:0]       ink
);
  p_set_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_sel == 8'h40 |=> idx == $past(wr_data[IDX_W-1:0]));

  p_c8_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_sel == 8'h41 |=> idx == IDX_W'($past(idx) + 1'b1));

  p_c9_first_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_sel == 8'h44 && !phase |=> $stable(idx) && phase);

  p_c9_second_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_sel == 8'h44 && phase |=> idx == IDX_W'($past(idx) + 1'b1) && !phase);

  p_seq_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (reg_sel == 8'h40 || reg_sel == 8'h41 || reg_sel == 8'h43) |=> !phase);

  p_ink_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && reg_sel == 8'h42) |=> $stable(ink));

  p_idle_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx) && $stable(phase));
endmodule

bind palreg_unit palreg_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .idx(idx_q), .phase(phase_q), .ink(ink_q)
);

// File: tb/sim_palreg_unit.sv
module sim_palreg_unit;
  localparam time TCLK = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_sel = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ext_mode;
  logic [2:0] dbg_pal = 3'd0;
  logic [7:0] dbg_idx = 8'd0;
  logic [8:0] dbg_color;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  palreg_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ext_mode(ext_mode),
    .dbg_pal(dbg_pal), .dbg_idx(dbg_idx), .dbg_color(dbg_color)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] r, input logic [7:0] d);
    @(negedge clk);
    reg_sel = r; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] r, input int exp);
    @(negedge clk);
    reg_sel = r;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic dbg(input string req, input logic [2:0] p, input logic [7:0] i, input int exp);
    dbg_pal = p; dbg_idx = i;
    #1;
    chk(req, dbg_color, exp);
  endtask

  task automatic t_reset;
    rd("R10 index", 8'h40, 8'h00);
    rd("R10 ctrl", 8'h43, 8'h00);
    rd("R10 ink", 8'h42, 8'h07);
    chk("R10 ext_mode", ext_mode, 0);
  endtask

  task automatic t_index_and_byte;
    wr(8'h40, 8'h70);
    rd("R1 index readback", 8'h40, 8'h70);
    wr(8'h41, 8'h1F);
    rd("R3 index advanced", 8'h40, 8'h71);
    dbg("R3 widened entry", 3'd0, 8'h70, 9'h03F);
    wr(8'h41, 8'h1C);
    dbg("R3 low bits clear", 3'd0, 8'h71, 9'h038);
    wr(8'h40, 8'h70);
    rd("R2 read entry", 8'h41, 8'h1F);
    rd("R2 read again", 8'h41, 8'h1F);
    rd("R2 index kept", 8'h40, 8'h70);
    rd("R5 ninth bit one", 8'h44, 8'h01);
    wr(8'h40, 8'h71);
    rd("R5 ninth bit zero", 8'h44, 8'h00);
  endtask

  task automatic t_select;
    wr(8'h40, 8'h05);
    wr(8'h41, 8'h11);
    wr(8'h43, 8'h68);
    rd("R4 ctrl readback", 8'h43, 8'h68);
    chk("R4 ext_mode off", ext_mode, 0);
    wr(8'h40, 8'h05);
    wr(8'h41, 8'hAB);
    dbg("R4 sprite secondary", 3'b110, 8'h05, 9'h157);
    dbg("R12 char primary untouched", 3'b000, 8'h05, 9'h023);
    wr(8'h43, 8'h31);
    chk("R4 ext_mode on", ext_mode, 1);
    wr(8'h40, 8'h06);
    wr(8'h41, 8'h42);
    dbg("R4 layer 11 aliases char", 3'b000, 8'h06, 9'h085);
  endtask

  task automatic t_nine;
    wr(8'h43, 8'h50);
    wr(8'h40, 8'h20);
    wr(8'h41, 8'h00);
    wr(8'h40, 8'h20);
    wr(8'h44, 8'hFF);
    rd("R6 first byte no advance", 8'h40, 8'h20);
    dbg("R6 first byte no store", 3'b101, 8'h20, 9'h000);
    wr(8'h40, 8'h10);
    wr(8'h44, 8'hC3);
    wr(8'h44, 8'h01);
    rd("R6 second byte advance", 8'h40, 8'h11);
    dbg("R6 stored nine bits", 3'b101, 8'h10, 9'h187);
    wr(8'h40, 8'h10);
    rd("R2 high bits", 8'h41, 8'hC3);
    rd("R5 low bit", 8'h44, 8'h01);
  endtask

  task automatic t_restart;
    wr(8'h44, 8'hAA);
    wr(8'h40, 8'h30);
    wr(8'h44, 8'h55);
    rd("R8 index after restart", 8'h40, 8'h30);
    wr(8'h44, 8'h00);
    dbg("R8 restart via index", 3'b101, 8'h30, 9'h0AA);
    wr(8'h44, 8'h77);
    wr(8'h43, 8'h50);
    wr(8'h44, 8'h0F);
    wr(8'h44, 8'h00);
    dbg("R8 restart via ctrl", 3'b101, 8'h31, 9'h01E);
    wr(8'h44, 8'h99);
    wr(8'h41, 8'h80);
    wr(8'h44, 8'h3C);
    wr(8'h44, 8'h01);
    dbg("R8 restart via color8", 3'b101, 8'h33, 9'h079);
  endtask

  task automatic t_wrap;
    wr(8'h40, 8'hFF);
    wr(8'h41, 8'h00);
    rd("R9 wrap byte path", 8'h40, 8'h00);
    wr(8'h40, 8'hFF);
    wr(8'h44, 8'h12);
    wr(8'h44, 8'h00);
    rd("R9 wrap pair path", 8'h40, 8'h00);
  endtask

  task automatic t_ink_and_unmapped;
    wr(8'h42, 8'h03);
    rd("R7 ink readback", 8'h42, 8'h03);
    wr(8'h40, 8'h44);
    wr(8'h45, 8'hFF);
    wr(8'h3F, 8'h12);
    rd("R11 index unchanged", 8'h40, 8'h44);
    rd("R11 ink unchanged", 8'h42, 8'h03);
    rd("R11 ctrl unchanged", 8'h43, 8'h50);
    rd("R11 unmapped read", 8'h45, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index_and_byte();
    t_select();
    t_nine();
    t_restart();
    t_wrap();
    t_ink_and_unmapped();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule